// File: doc/BRIEF.md
# Software-Generated Interrupt Admission Filter

This block sits between the source of software-generated interrupt requests and the pending-state register bank of one processing element's sixteen local interrupts. Each request names an interrupt ID, the group the sender asks for and whether it comes from the non-secure side. The filter looks up that interrupt's configured group and its two-bit non-secure access field, then either accepts the request or drops it without any response.

An accepted request becomes a registered, one-cycle, one-hot set-pending strobe for the chosen interrupt. It comes with a one-cycle rescan strobe that tells the priority logic to recompute the highest-priority pending interrupt. A request whose ID lies outside the sixteen local interrupts sets nothing and raises a one-cycle error strobe. The request port uses a valid/ready handshake, and ready is always high, so a request is consumed in the cycle in which valid is high.

Top module: `sgi_admit_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it, the set-pending strobe, the rescan strobe and the error strobe are all low.
- R2: `req_ready_o` is high in every cycle, including during reset.
- R3: A valid request that is accepted drives exactly bit `req_id_i` of `set_pend_o` and `rescan_o` high in the cycle after the request is sampled, for that one cycle only.
- R4: Group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, and 3 is treated as 2. These codes apply both to the request and to each interrupt's configured field, which sits at bits [2i+1:2i] of `grp_cfg_i`. A secure-group-1 request to an interrupt configured as group 0 is handled as a group 0 request.
- R5: A group 0 request (after the rule of R4) to an interrupt whose configured group is not group 0 is dropped.
- R6: When `sec_off_i` is low and `req_ns_i` is high, a request to a group 0 interrupt is accepted only if its access field (bits [2i+1:2i] of `acc_cfg_i`) is 1 or more.
- R7: Under the same conditions as R6, a request to a secure group 1 interrupt is accepted only if its access field is 2 or more.
- R8: When `sec_off_i` is high, or when the request is secure, the access field has no effect on the outcome.
- R9: A valid request with an ID of 16 or more sets no pending bit and raises `bad_id_o` for exactly the following cycle.
- R10: With `req_valid_i` low, no strobe is raised, whatever the other request inputs are.
- R11: Requests to a non-secure group 1 interrupt are accepted whatever the access field, unless R5 drops them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted for evaluation (always high) |
| req_id_i | input | 5 | Requested interrupt ID |
| req_grp_i | input | 2 | Requested group code |
| req_ns_i | input | 1 | Request comes from the non-secure side |
| sec_off_i | input | 1 | Global security-disable |
| grp_cfg_i | input | 32 | Configured group of each interrupt, 2 bits each |
| acc_cfg_i | input | 32 | Non-secure access field of each interrupt, 2 bits each |
| set_pend_o | output | 16 | One-hot set-pending strobe |
| rescan_o | output | 1 | Recompute highest-priority pending interrupt |
| bad_id_o | output | 1 | Out-of-range ID strobe |

## Verification
The filter has a single register stage, so any wrong decision shows up on `set_pend_o` in the cycle after the request is sampled. A missed threshold or a wrong demotion shows as a strobe that should be absent, or as a missing strobe. A wrong ID decode shows as the wrong bit or as more than one bit. A stuck output register shows as a strobe that outlives its single cycle, which becomes visible one cycle later when valid has dropped. The directed cases pair each group configuration with each access threshold and each origin, so every comparison boundary is tested on both sides.

// File: rtl/sgi_adm_pkg.sv
package sgi_adm_pkg;

    localparam int GRP_W = 2;
    localparam int ACC_W = 2;

    typedef enum logic [GRP_W-1:0] {
        GRP_0        = 2'd0,
        GRP_1_SEC    = 2'd1,
        GRP_1_NSEC   = 2'd2,
        GRP_1_NSEC_X = 2'd3
    } grp_e;

    typedef struct packed {
        logic             from_ns;
        logic             sec_off;
        grp_e             asked;
        grp_e             cfg;
        logic [ACC_W-1:0] acc;
    } rule_in_t;

    typedef enum logic [1:0] {
        VERD_IDLE   = 2'd0,
        VERD_ACCEPT = 2'd1,
        VERD_DROP   = 2'd2,
        VERD_BAD_ID = 2'd3
    } verdict_e;

    // Code 3 is an alias of non-secure group 1.
    function automatic grp_e grp_norm(input grp_e g);
        return (g == GRP_1_NSEC_X) ? GRP_1_NSEC : g;
    endfunction

    // Secure group 1 asked of a group 0 interrupt becomes group 0.
    function automatic grp_e grp_demote(input grp_e asked, input grp_e cfg);
        if (cfg == GRP_0 && asked == GRP_1_SEC)
            return GRP_0;
        return asked;
    endfunction

    // Minimum access level a non-secure sender needs, per configured group.
    function automatic logic ns_permits(input grp_e cfg, input logic [ACC_W-1:0] acc);
        case (cfg)
            GRP_0:     return acc >= ACC_W'(1);
            GRP_1_SEC: return acc >= ACC_W'(2);
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sgi_id_decode.sv
module sgi_id_decode #(
    parameter int NUM_INT = 16,
    parameter int ID_W    = 5,
    localparam int SEL_W  = $clog2(NUM_INT)
) (
    input  logic [ID_W-1:0]    id_i,
    output logic               in_range_o,
    output logic [SEL_W-1:0]   idx_o,
    output logic [NUM_INT-1:0] onehot_o
);

    assign in_range_o = (id_i < ID_W'(NUM_INT));
    assign idx_o      = id_i[SEL_W-1:0];

    for (genvar i = 0; i < NUM_INT; i++) begin : g_hot
        assign onehot_o[i] = in_range_o && (id_i == ID_W'(i));
    end

endmodule

// File: rtl/sgi_cfg_select.sv
module sgi_cfg_select
    import sgi_adm_pkg::*;
#(
    parameter int NUM_INT = 16,
    localparam int SEL_W  = $clog2(NUM_INT)
) (
    input  logic [NUM_INT*GRP_W-1:0] grp_cfg_i,
    input  logic [NUM_INT*ACC_W-1:0] acc_cfg_i,
    input  logic [SEL_W-1:0]         idx_i,
    output grp_e                     grp_o,
    output logic [ACC_W-1:0]         acc_o
);

    logic [GRP_W-1:0] grp_arr [NUM_INT];
    logic [ACC_W-1:0] acc_arr [NUM_INT];

    for (genvar i = 0; i < NUM_INT; i++) begin : g_unpack
        assign grp_arr[i] = grp_cfg_i[i*GRP_W +: GRP_W];
        assign acc_arr[i] = acc_cfg_i[i*ACC_W +: ACC_W];
    end

    always_comb begin
        grp_o = grp_e'(grp_arr[idx_i]);
        acc_o = acc_arr[idx_i];
    end

endmodule

// File: rtl/sgi_rule_eval.sv
module sgi_rule_eval
    import sgi_adm_pkg::*;
(
    input  rule_in_t rule_i,
    output logic     accept_o
);

    grp_e cfg_n;
    grp_e asked_n;
    grp_e eff;

    always_comb begin
        cfg_n   = grp_norm(rule_i.cfg);
        asked_n = grp_norm(rule_i.asked);
        eff     = grp_demote(asked_n, cfg_n);
        if (eff == GRP_0 && cfg_n != GRP_0)
            accept_o = 1'b0;
        else if (rule_i.from_ns && !rule_i.sec_off && !ns_permits(cfg_n, rule_i.acc))
            accept_o = 1'b0;
        else
            accept_o = 1'b1;
    end

endmodule

// File: rtl/sgi_admit_filter.sv
module sgi_admit_filter
    import sgi_adm_pkg::*;
#(
    parameter int NUM_INT = 16,
    parameter int ID_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [ID_W-1:0]          req_id_i,
    input  logic [1:0]               req_grp_i,
    input  logic                     req_ns_i,
    input  logic                     sec_off_i,
    input  logic [NUM_INT*GRP_W-1:0] grp_cfg_i,
    input  logic [NUM_INT*ACC_W-1:0] acc_cfg_i,
    output logic [NUM_INT-1:0]       set_pend_o,
    output logic                     rescan_o,
    output logic                     bad_id_o
);

    localparam int SEL_W = $clog2(NUM_INT);

    logic               in_range;
    logic [SEL_W-1:0]   idx;
    logic [NUM_INT-1:0] onehot;
    grp_e               cfg_grp;
    logic [ACC_W-1:0]   cfg_acc;
    rule_in_t           rule;
    logic               accept;
    verdict_e           verdict;

    logic [NUM_INT-1:0] set_q;
    logic               rescan_q;
    logic               bad_q;

    assign req_ready_o = 1'b1;

    sgi_id_decode #(.NUM_INT(NUM_INT), .ID_W(ID_W)) u_dec (
        .id_i       (req_id_i),
        .in_range_o (in_range),
        .idx_o      (idx),
        .onehot_o   (onehot)
    );

    sgi_cfg_select #(.NUM_INT(NUM_INT)) u_sel (
        .grp_cfg_i (grp_cfg_i),
        .acc_cfg_i (acc_cfg_i),
        .idx_i     (idx),
        .grp_o     (cfg_grp),
        .acc_o     (cfg_acc)
    );

    always_comb begin
        rule.from_ns = req_ns_i;
        rule.sec_off = sec_off_i;
        rule.asked   = grp_e'(req_grp_i);
        rule.cfg     = cfg_grp;
        rule.acc     = cfg_acc;
    end

    sgi_rule_eval u_rule (
        .rule_i   (rule),
        .accept_o (accept)
    );

    always_comb begin
        if (!req_valid_i)
            verdict = VERD_IDLE;
        else if (!in_range)
            verdict = VERD_BAD_ID;
        else if (accept)
            verdict = VERD_ACCEPT;
        else
            verdict = VERD_DROP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q    <= '0;
            rescan_q <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            set_q    <= (verdict == VERD_ACCEPT) ? onehot : '0;
            rescan_q <= (verdict == VERD_ACCEPT);
            bad_q    <= (verdict == VERD_BAD_ID);
        end
    end

    assign set_pend_o = set_q;
    assign rescan_o   = rescan_q;
    assign bad_id_o   = bad_q;

endmodule

// File: rtl/sgi_admit_filter_chk.sv
module sgi_admit_filter_chk
    import sgi_adm_pkg::*;
#(
    parameter int NUM_INT = 16,
    parameter int ID_W    = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid_i,
    input logic [ID_W-1:0]          req_id_i,
    input logic [1:0]               req_grp_i,
    input logic                     req_ns_i,
    input logic                     sec_off_i,
    input logic [NUM_INT*GRP_W-1:0] grp_cfg_i,
    input logic [NUM_INT*ACC_W-1:0] acc_cfg_i,
    input logic [NUM_INT-1:0]       set_pend_o,
    input logic                     rescan_o,
    input logic                     bad_id_o
);

    localparam int SEL_W = $clog2(NUM_INT);

    logic             id_ok;
    logic [1:0]       c_grp;
    logic [1:0]       c_acc;
    logic             ns_chk;

    assign id_ok  = req_id_i < ID_W'(NUM_INT);
    assign c_grp  = grp_cfg_i[req_id_i[SEL_W-1:0]*GRP_W +: GRP_W];
    assign c_acc  = acc_cfg_i[req_id_i[SEL_W-1:0]*ACC_W +: ACC_W];
    assign ns_chk = req_valid_i && id_ok && req_ns_i && !sec_off_i;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (set_pend_o == '0 && !rescan_o && !bad_id_o)); // R1

    AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_pend_o)); // R3

    AST_SET_MATCH_ID: assert property (@(posedge clk) disable iff (rst)
        (set_pend_o != '0) |-> (set_pend_o == (NUM_INT'(1) << $past(req_id_i[SEL_W-1:0])))); // R3

    AST_RESCAN_WITH_SET: assert property (@(posedge clk) disable iff (rst)
        rescan_o == (set_pend_o != '0)); // R3

    AST_G0_MISMATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && id_ok && req_grp_i == 2'd0 && c_grp != 2'd0) |=> (set_pend_o == '0)); // R5

    AST_NS_G0_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ns_chk && c_grp == 2'd0 && c_acc == 2'd0) |=> (set_pend_o == '0)); // R6

    AST_NS_G1S_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ns_chk && c_grp == 2'd1 && c_acc < 2'd2) |=> (set_pend_o == '0)); // R7

    AST_BAD_ID_FLAG: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !id_ok) |=> (bad_id_o && set_pend_o == '0)); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (set_pend_o == '0 && !bad_id_o)); // R10

endmodule

bind sgi_admit_filter sgi_admit_filter_chk #(.NUM_INT(NUM_INT), .ID_W(ID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_id_i    (req_id_i),
    .req_grp_i   (req_grp_i),
    .req_ns_i    (req_ns_i),
    .sec_off_i   (sec_off_i),
    .grp_cfg_i   (grp_cfg_i),
    .acc_cfg_i   (acc_cfg_i),
    .set_pend_o  (set_pend_o),
    .rescan_o    (rescan_o),
    .bad_id_o    (bad_id_o)
);

// File: tb/sgi_admit_filter_bench.sv
module sgi_admit_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_INT    = 16;
    localparam int ID_W       = 5;
    localparam int WD_CYCLES  = 5000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [ID_W-1:0]      req_id = '0;
    logic [1:0]           req_grp = '0;
    logic                 req_ns = 1'b0;
    logic                 sec_off = 1'b0;
    logic [2*NUM_INT-1:0] grp_cfg = '0;
    logic [2*NUM_INT-1:0] acc_cfg = '0;
    logic [NUM_INT-1:0]   set_pend;
    logic                 rescan;
    logic                 bad_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_admit_filter #(.NUM_INT(NUM_INT), .ID_W(ID_W)) u_sgi_admit_filter (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_id_i    (req_id),
        .req_grp_i   (req_grp),
        .req_ns_i    (req_ns),
        .sec_off_i   (sec_off),
        .grp_cfg_i   (grp_cfg),
        .acc_cfg_i   (acc_cfg),
        .set_pend_o  (set_pend),
        .rescan_o    (rescan),
        .bad_id_o    (bad_id)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_cfg(input int id, input logic [1:0] g, input logic [1:0] a);
        grp_cfg[2*id +: 2] = g;
        acc_cfg[2*id +: 2] = a;
    endtask

    // Issue one request, check the strobe cycle, then the cycle after.
    task automatic send(input int id, input logic [1:0] g, input logic ns,
                        input logic exp_acc, input string tag);
        logic [NUM_INT-1:0] exp_set;
        logic               exp_bad;
        exp_bad = (id >= NUM_INT);
        exp_set = (exp_acc && !exp_bad) ? (NUM_INT'(1) << id) : '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_id    = ID_W'(id);
        req_grp   = g;
        req_ns    = ns;
        @(posedge clk);
        #1;
        check({tag, " set"}, 32'(set_pend), 32'(exp_set));
        check({tag, " rescan"}, 32'(rescan), 32'(exp_acc && !exp_bad));
        check({tag, " bad"}, 32'(bad_id), 32'(exp_bad));
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check({tag, " one-cycle"}, {14'd0, bad_id, rescan, set_pend}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset set", 32'(set_pend), 32'd0);
        check("R1 reset flags", {30'd0, rescan, bad_id}, 32'd0);
        check("R2 ready in reset", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 first cycle", {14'd0, bad_id, rescan, set_pend}, 32'd0);
        check("R2 ready after reset", 32'(req_ready), 32'd1);
    endtask

    task automatic t_accept();
        send(4, 2'd2, 1'b0, 1'b1, "R3 secure g1ns id4");
        send(15, 2'd0, 1'b0, 1'b1, "R3 secure g0 id15");
        send(3, 2'd1, 1'b0, 1'b1, "R3 secure g1s id3");
    endtask

    task automatic t_demote();
        send(1, 2'd1, 1'b0, 1'b1, "R4 demote secure id1");
        send(1, 2'd1, 1'b1, 1'b1, "R4 demote ns acc1 id1");
        send(0, 2'd1, 1'b1, 1'b0, "R4 demote ns acc0 id0");
        send(1, 2'd3, 1'b0, 1'b1, "R4 code3 request id1");
    endtask

    task automatic t_g0_mismatch();
        send(3, 2'd0, 1'b0, 1'b0, "R5 g0 to g1s id3");
        send(4, 2'd0, 1'b0, 1'b0, "R5 g0 to g1ns id4");
        send(6, 2'd0, 1'b1, 1'b0, "R5 g0 to code3 id6");
    endtask

    task automatic t_ns_levels();
        send(0, 2'd0, 1'b1, 1'b0, "R6 ns g0 acc0");
        send(1, 2'd0, 1'b1, 1'b1, "R6 ns g0 acc1");
        send(15, 2'd0, 1'b1, 1'b1, "R6 ns g0 acc2");
        send(2, 2'd1, 1'b1, 1'b0, "R7 ns g1s acc1");
        send(7, 2'd1, 1'b1, 1'b0, "R7 ns g1s acc0");
        send(3, 2'd1, 1'b1, 1'b1, "R7 ns g1s acc2");
        send(5, 2'd1, 1'b1, 1'b1, "R7 ns g1s acc3");
    endtask

    task automatic t_sec_off();
        send(0, 2'd0, 1'b0, 1'b1, "R8 secure g0 acc0");
        send(2, 2'd1, 1'b0, 1'b1, "R8 secure g1s acc1");
        @(negedge clk);
        sec_off = 1'b1;
        send(0, 2'd0, 1'b1, 1'b1, "R8 secoff ns g0 acc0");
        send(2, 2'd1, 1'b1, 1'b1, "R8 secoff ns g1s acc1");
        send(3, 2'd0, 1'b1, 1'b0, "R8 secoff still R5");
        @(negedge clk);
        sec_off = 1'b0;
    endtask

    task automatic t_bad_id();
        send(16, 2'd0, 1'b0, 1'b0, "R9 id16");
        send(31, 2'd2, 1'b1, 1'b0, "R9 id31");
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_id    = 5'd20;
        req_grp   = 2'd0;
        req_ns    = 1'b0;
        @(posedge clk);
        #1;
        check("R10 idle bad id", {14'd0, bad_id, rescan, set_pend}, 32'd0);
        @(negedge clk);
        req_id = 5'd0;
        @(posedge clk);
        #1;
        check("R10 idle good id", {14'd0, bad_id, rescan, set_pend}, 32'd0);
    endtask

    task automatic t_g1ns();
        send(4, 2'd2, 1'b1, 1'b1, "R11 ns g1ns acc0");
        send(4, 2'd1, 1'b1, 1'b1, "R11 ns g1s ask g1ns");
        send(6, 2'd2, 1'b1, 1'b1, "R11 ns code3 cfg");
    endtask

    initial begin
        put_cfg(0, 2'd0, 2'd0);
        put_cfg(1, 2'd0, 2'd1);
        put_cfg(2, 2'd1, 2'd1);
        put_cfg(3, 2'd1, 2'd2);
        put_cfg(4, 2'd2, 2'd0);
        put_cfg(5, 2'd1, 2'd3);
        put_cfg(6, 2'd3, 2'd0);
        put_cfg(7, 2'd1, 2'd0);
        put_cfg(15, 2'd0, 2'd2);
        repeat (3) @(posedge clk);
        t_reset();
        t_accept();
        t_demote();
        t_g0_mismatch();
        t_ns_levels();
        t_sec_off();
        t_bad_id();
        t_idle();
        t_g1ns();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule